// File: doc/BRIEF.md
# Palette Colour Table Host Port

This block gives a host byte-wide access to a 256-entry colour table. Each entry holds three 8-bit components: red, green and blue. The host reaches the table through four byte lanes of one 32-bit register. It loads a write pointer or a read pointer, then streams the components of successive entries through the data lane, red first. A small sequencer counts the components. After each complete triplet it moves the active pointer to the next entry.

The two pointers are held apart, but one component counter serves both. Every data byte written is ANDed with a host-programmable pixel mask before it is staged. An entry goes into the table only when its third component arrives. On the read side, the whole entry is fetched into a staging buffer on the red access. The green and blue accesses then return bytes from that buffer. Read data is registered and appears on the output after the clock edge of the read access.

Top module: `palette_host_port`

## Requirements
- R1: After reset the write pointer and read pointer are 0, the pixel mask is 0xFF and the component counter is 0.
- R2: Lanes are decoded as laneSel 0 = write pointer, 1 = colour data, 2 = pixel mask, 3 = read pointer. A read of lane 0, 2 or 3 returns that register on rdByte after the access edge.
- R3: A write to lane 0 or lane 3 returns the shared component counter to 0.
- R4: Each data write stages (wrByte AND mask) at the current component position, in the order red, green, blue.
- R5: The third data write stores the triplet {red, green, blue} at the write pointer, advances the write pointer by one and returns the counter to 0.
- R6: A data read with the counter at 0 fetches the entry at the read pointer into staging and returns its red byte.
- R7: The next two data reads return green and then blue. After blue, the read pointer advances by one and the counter returns to 0.
- R8: Both pointers wrap from 255 to 0.
- R9: The mask applies only when data is written. Changing the mask does not alter entries already stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Access strobe, one access per cycle |
| accWr | input | 1 | 1 = write access, 0 = read access |
| laneSel | input | 2 | Byte lane addressed by the access |
| wrByte | input | 8 | Write data byte |
| rdByte | output | 8 | Registered read data byte |

## Verification
The bench builds the block with the package defaults: 8-bit pointers, 8-bit components and a 256-entry table. With these widths, the wrap from entry 255 to entry 0 is only a few accesses away from a pointer load. The bench mixes partial triplets, pointer reloads and mask changes so that the shared counter and the write-time masking can be observed at the read lane.

// File: rtl/palette_port_pkg.sv
package palette_port_pkg;
  localparam int IDX_W  = 8;
  localparam int CH_W   = 8;
  localparam int NCOMP  = 3;
  localparam int CMP_W  = $clog2(NCOMP + 1);
  localparam int ENT_W  = CH_W * NCOMP;
  localparam int DEPTH  = 1 << IDX_W;

  typedef enum logic [1:0] {
    LANE_WPTR = 2'd0,
    LANE_DATA = 2'd1,
    LANE_MASK = 2'd2,
    LANE_RPTR = 2'd3
  } lane_e;

  typedef struct packed {
    logic              wrAcc;
    logic              rdAcc;
    lane_e             lane;
    logic [CMP_W-1:0]  comp;
    logic [IDX_W-1:0]  wrIdx;
    logic [IDX_W-1:0]  rdIdx;
    logic [CH_W-1:0]   mask;
  } strobe_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_port_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            accEn,
  input  logic            accWr,
  input  logic [1:0]      laneSel,
  input  logic [CH_W-1:0] wrByte,
  output strobe_t         stb
);
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [CH_W-1:0]  mask;
  logic [CMP_W-1:0] comp;
  logic             isWr, isRd, lastComp;
  lane_e            lane;

  always_comb begin
    lane     = lane_e'(laneSel);
    isWr     = accEn && accWr;
    isRd     = accEn && !accWr;
    lastComp = (comp == CMP_W'(NCOMP - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      mask  <= '1;
      comp  <= '0;
    end else if (isWr) begin
      case (lane)
        LANE_WPTR: begin wrIdx <= wrByte; comp <= '0; end
        LANE_RPTR: begin rdIdx <= wrByte; comp <= '0; end
        LANE_MASK: mask <= wrByte;
        default: begin
          if (lastComp) begin
            comp  <= '0;
            wrIdx <= wrIdx + 1'b1;
          end else begin
            comp <= comp + 1'b1;
          end
        end
      endcase
    end else if (isRd && lane == LANE_DATA) begin
      if (lastComp) begin
        comp  <= '0;
        rdIdx <= rdIdx + 1'b1;
      end else begin
        comp <= comp + 1'b1;
      end
    end
  end

  always_comb begin
    stb.wrAcc = isWr;
    stb.rdAcc = isRd;
    stb.lane  = lane;
    stb.comp  = comp;
    stb.wrIdx = wrIdx;
    stb.rdIdx = rdIdx;
    stb.mask  = mask;
  end

  // R3
  ptr_load_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && (lane == LANE_WPTR || lane == LANE_RPTR)) |=> (comp == '0));

  // R5
  wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && lane == LANE_DATA && lastComp) |=> (wrIdx == $past(wrIdx) + 1'b1 && comp == '0));

  // R7
  rd_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && lane == LANE_DATA && lastComp) |=> (rdIdx == $past(rdIdx) + 1'b1 && comp == '0));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (comp < CMP_W'(NCOMP)));
endmodule

// File: rtl/palette_data.sv
module palette_data
  import palette_port_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [CH_W-1:0] wrByte,
  output logic [CH_W-1:0] rdData
);
  logic [ENT_W-1:0] table_q [DEPTH];
  logic [CH_W-1:0]  stage [NCOMP];
  logic [CH_W-1:0]  maskedByte, stagedSel, redOut;
  logic [ENT_W-1:0] entryRd;
  logic             dataWr, dataRd, commit, fetch;

  always_comb begin
    maskedByte = wrByte & stb.mask;
    dataWr     = stb.wrAcc && stb.lane == LANE_DATA;
    dataRd     = stb.rdAcc && stb.lane == LANE_DATA;
    commit     = dataWr && stb.comp == CMP_W'(NCOMP - 1);
    fetch      = dataRd && stb.comp == '0;
    entryRd    = table_q[stb.rdIdx];
    redOut     = entryRd[ENT_W-1 -: CH_W];
    stagedSel  = stage[0];
    for (int i = 1; i < NCOMP; i++)
      if (stb.comp == CMP_W'(i)) stagedSel = stage[i];
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      table_q[stb.wrIdx] <= {stage[0], stage[1], maskedByte};
    end
  end

  for (genvar g = 0; g < NCOMP; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN)
        stage[g] <= '0;
      else if (dataWr && stb.comp == CMP_W'(g))
        stage[g] <= maskedByte;
      else if (fetch)
        stage[g] <= entryRd[ENT_W-1-g*CH_W -: CH_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdAcc) begin
      case (stb.lane)
        LANE_WPTR: rdData <= CH_W'(stb.wrIdx);
        LANE_MASK: rdData <= stb.mask;
        LANE_RPTR: rdData <= CH_W'(stb.rdIdx);
        default:   rdData <= fetch ? redOut : stagedSel;
      endcase
    end
  end

  // R2
  mask_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdAcc && stb.lane == LANE_MASK) |=> (rdData == $past(stb.mask)));

  // R6
  red_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetch |=> (rdData == stage[0]));
endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
  import palette_port_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            accEn,
  input  logic            accWr,
  input  logic [1:0]      laneSel,
  input  logic [7:0]      wrByte,
  output logic [7:0]      rdByte
);
  strobe_t stb;

  palette_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr),
    .laneSel(laneSel), .wrByte(wrByte), .stb(stb)
  );

  palette_data u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(wrByte), .rdData(rdByte)
  );
endmodule

// File: tb/test_palette_host_port.sv
module test_palette_host_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accEn = 1'b0, accWr = 1'b0;
  logic [1:0] laneSel = 2'd0;
  logic [7:0] wrByte = 8'd0;
  logic [7:0] rdByte;
  int applied = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  palette_host_port i_palette_host_port (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr),
    .laneSel(laneSel), .wrByte(wrByte), .rdByte(rdByte)
  );

  // {chk, wr, lane[1:0]} | data | expected
  localparam int NV = 23;
  localparam logic [19:0] VEC [NV] = '{
    20'h4_10_00, // set write pointer 0x10
    20'h5_AA_00, 20'h5_55_00, 20'h5_0F_00, // R4 R5 triplet to entry 0x10
    20'h8_00_11, // R5 R2 write pointer advanced
    20'h6_F0_00, // mask = F0
    20'hA_00_F0, // R2 mask readback
    20'h5_FF_00, 20'h5_3C_00, 20'h5_81_00, // R4 masked triplet to entry 0x11
    20'h7_10_00, // read pointer 0x10
    20'h9_00_AA, 20'h9_00_55, 20'h9_00_0F, // R6 R7 R9 entry 0x10 intact
    20'h9_00_F0, 20'h9_00_30, 20'h9_00_80, // R4 R7 masked entry 0x11
    20'hB_00_12, // R7 read pointer advanced twice
    20'h7_10_00, 20'h9_00_AA, // partial read
    20'h7_10_00, 20'h9_00_AA, // R3 counter cleared by pointer load
    20'hB_00_10  // R3 read pointer not advanced
  };

  task automatic acc(input logic wr, input logic [1:0] ln, input logic [7:0] d);
    @(negedge clk);
    accEn = 1'b1; accWr = wr; laneSel = ln; wrByte = d;
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] exp);
    applied++;
    if (rdByte !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, rdByte, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state through the register lanes
    acc(1'b0, 2'd0, 8'h00); chk("R1", 8'h00);
    acc(1'b0, 2'd2, 8'h00); chk("R1", 8'hFF);
    acc(1'b0, 2'd3, 8'h00); chk("R1", 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
      if (VEC[i][19]) chk("R2-R9 vector", VEC[i][7:0]);
    end

    // R8 write pointer wrap
    acc(1'b1, 2'd2, 8'hFF);
    acc(1'b1, 2'd0, 8'hFF);
    acc(1'b1, 2'd1, 8'h12); acc(1'b1, 2'd1, 8'h34); acc(1'b1, 2'd1, 8'h56);
    acc(1'b0, 2'd0, 8'h00); chk("R8", 8'h00);
    // R8 read pointer wrap
    acc(1'b1, 2'd3, 8'hFF);
    acc(1'b0, 2'd1, 8'h00); chk("R8", 8'h12);
    acc(1'b0, 2'd1, 8'h00); chk("R8", 8'h34);
    acc(1'b0, 2'd1, 8'h00); chk("R8", 8'h56);
    acc(1'b0, 2'd3, 8'h00); chk("R8", 8'h00);

    // R1 reset restores mask and counter
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    acc(1'b0, 2'd2, 8'h00); chk("R1", 8'hFF);
    acc(1'b1, 2'd3, 8'h10);
    acc(1'b0, 2'd1, 8'h00); chk("R1", 8'hAA);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule